// File: doc/BRIEF.md
# Time-Slotted Synchronous SRAM Controller

This controller shares one external flow-through synchronous SRAM (64K words, 16-bit address) among eleven internal clients. Each client owns one slot of a 12-clock access frame that repeats without pause. Six read slots come first, then one dummy slot that lets the data bus turn around, then five write slots. The address strobe and output-enable pins follow the same waveform in every frame. Chip select, and write enable for writes, are asserted only in slots whose owner has a request waiting. This is what decides whether a slot touches memory.

A client pulses its request line once, together with its address and, for writers, its data. The controller holds the request until the client's slot comes round. If a request arrives while its own slot is already on the pins, it waits for the same slot in the next frame. Read data comes back on a shared bus with a one-cycle valid strobe for the owning reader. With parity enabled, the controller stores a 33rd bit on writes and flags a parity mismatch on reads.

Top module: `tslot_sram_ctrl`

## Requirements
- R1: Slots are numbered 0 to 11 and repeat. Reads are slots 0-5 (reader n owns slot n), the dummy is slot 6, and writes are slots 7-11 (writer m owns slot 7+m). Once running, `sram_adsc_n` is low in every cycle and `sram_oe_n` is low exactly in slots 1 to 6, whatever the requests.
- R2: `sram_addr` shows the most recently requested address of the slot's owner, 0 if that owner has never requested, and 0 in the dummy slot.
- R3: `sram_cs_n` is low in a slot only if the owner has a pending request. It is high in the dummy slot. A slot with no request has no effect on memory or on the outputs.
- R4: `sram_we_n` is low only in a write slot with a pending request. In that same cycle `sram_dq_out[31:0]` carries the write data and bit 32 carries the XOR of bits 31:0 (even parity).
- R5: `sram_dq_oe` is high exactly in slots 7 to 11, and never together with a low `sram_oe_n`.
- R6: For a served read in slot n, `rd_valid` equals 1<<n for one cycle in slot n+2. At that time `rd_data` holds bits 31:0 that the SRAM returned in slot n+1. At all other times `rd_valid` is zero.
- R7: When parity is enabled, `rd_perr` has bit n set together with `rd_valid[n]` if the 33 returned bits have odd parity, and it is zero otherwise.
- R8: A request raised in its own slot's cycle is not served in that slot. It is served in the same slot of the next frame.
- R9: `wr_done[m]` pulses for one cycle in the cycle after writer m's slot was served.
- R10: While `rst_n` is low, chip select and write enable are high, `sram_oe_n` is high, `sram_dq_oe` is low, and all strobes are zero. Slot 1 starts in the third cycle after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SRAM |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 6 | One-cycle request pulse per reader |
| rd_addr | input | 96 | Reader addresses, reader n at bits 16n+15:16n |
| rd_valid | output | 6 | One-hot read-return strobe |
| rd_data | output | 32 | Returned read word |
| rd_perr | output | 6 | Parity error flag, aligned with rd_valid |
| wr_req | input | 5 | One-cycle request pulse per writer |
| wr_addr | input | 80 | Writer addresses, writer m at bits 16m+15:16m |
| wr_data | input | 160 | Writer data, writer m at bits 32m+31:32m |
| wr_done | output | 5 | Write-served pulse per writer |
| sram_addr | output | 16 | SRAM address |
| sram_adsc_n | output | 1 | Address strobe, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_out | output | 33 | Data driven to the SRAM, bit 32 parity |
| sram_dq_in | input | 33 | Data returned from the SRAM |

## Verification
The bench drives frames with every slot active, with a sparse mix of slots (reads in slots 0 and 2, writes in slots 7 and 9), with alternating slots, and with no requests at all. Comparing these frames shows that chip select follows requests slot by slot, while the strobe, output-enable and drive-enable waveforms stay fixed. Pairing a write frame with a later read frame at overlapping addresses shows that data and parity reach memory and come back intact. A frame with one corrupted returned bit separates correct parity flagging from the clean case. A request raised during its own slot separates holding it over to the next frame from serving it too late in the current one.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

  typedef enum logic [1:0] {
    SLOT_RD  = 2'd0,
    SLOT_GAP = 2'd1,
    SLOT_WR  = 2'd2
  } slot_kind_e;

endpackage

// File: rtl/tslot_rst_sync.sv
module tslot_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/tslot_seq.sv
module tslot_seq
  import tslot_pkg::*;
#(
  parameter int N_RD = 6,
  parameter int N_WR = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  output slot_kind_e      kind_o,
  output logic [N_RD-1:0] rd_sel_o,
  output logic [N_WR-1:0] wr_sel_o,
  output logic            oe_win_o
);

  localparam int FRAME = N_RD + 1 + N_WR;
  localparam int SW    = $clog2(FRAME);
  localparam int GAP   = N_RD;
  localparam logic [SW-1:0] LAST = SW'(FRAME - 1);

  logic [SW-1:0] slot_q, slot_d;

  always_comb begin
    slot_d = (slot_q == LAST) ? '0 : slot_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  always_comb begin
    if (slot_q < SW'(GAP))       kind_o = SLOT_RD;
    else if (slot_q == SW'(GAP)) kind_o = SLOT_GAP;
    else                         kind_o = SLOT_WR;
  end

  for (genvar i = 0; i < N_RD; i++) begin : g_rsel
    assign rd_sel_o[i] = (slot_q == SW'(i));
  end

  for (genvar j = 0; j < N_WR; j++) begin : g_wsel
    assign wr_sel_o[j] = (slot_q == SW'(GAP + 1 + j));
  end

  assign oe_win_o = (slot_q >= SW'(1)) && (slot_q <= SW'(N_RD));

  // R1: the frame closes after its last slot and restarts at slot 0
  p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == LAST) |=> (slot_q == '0));

  // R1: at most one owner is selected in any slot
  p_sel_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_sel_o, wr_sel_o}));

endmodule

// File: rtl/tslot_req_bank.sv
module tslot_req_bank #(
  parameter int N  = 6,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic [N*PW-1:0] pay_i,
  input  logic [N-1:0]  serve_i,
  output logic [N-1:0]  pend_o,
  output logic [N*PW-1:0] pay_o,
  output logic [N-1:0]  done_o
);

  logic [N-1:0]    pend_q, pend_d;
  logic [N-1:0]    done_q, done_d;
  logic [N*PW-1:0] pay_q, pay_d;

  always_comb begin
    pend_d = (pend_q & ~serve_i) | req_i;
    done_d = pend_q & serve_i;
    pay_d  = pay_q;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) pay_d[i*PW +: PW] = pay_i[i*PW +: PW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      done_q <= '0;
      pay_q  <= '0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
      pay_q  <= pay_d;
    end
  end

  assign pend_o = pend_q;
  assign pay_o  = pay_q;
  assign done_o = done_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R8: a request raised during its own slot stays pending for the next frame
    p_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[i] && serve_i[i]) |=> pend_q[i]);
    // R3: a served request leaves nothing behind
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && serve_i[i] && !req_i[i]) |=> !pend_q[i]);
  end

endmodule

// File: rtl/tslot_rd_return.sv
module tslot_rd_return #(
  parameter int N   = 6,
  parameter int DW  = 32,
  parameter int PAR = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    take_i,
  input  logic [DW+PAR-1:0] dq_i,
  output logic [N-1:0]    valid_o,
  output logic [DW-1:0]   data_o,
  output logic [N-1:0]    perr_o
);

  logic          bad;
  logic [N-1:0]  valid_q, valid_d;
  logic [N-1:0]  perr_q, perr_d;
  logic [DW-1:0] data_q, data_d;

  if (PAR != 0) begin : g_par
    assign bad = ^dq_i;
  end else begin : g_nopar
    assign bad = 1'b0;
  end

  always_comb begin
    valid_d = take_i;
    perr_d  = take_i & {N{bad}};
    data_d  = (|take_i) ? dq_i[DW-1:0] : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      perr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      perr_q  <= perr_d;
      data_q  <= data_d;
    end
  end

  assign valid_o = valid_q;
  assign perr_o  = perr_q;
  assign data_o  = data_q;

  // R6: a reader's strobe never lasts two cycles
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|valid_q) |=> ((valid_q & $past(valid_q)) == '0));

  // R7: an error flag only accompanies a valid strobe
  p_perr_in_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((perr_q & ~valid_q) == '0));

endmodule

// File: rtl/tslot_sram_ctrl.sv
module tslot_sram_ctrl
  import tslot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int PAR_EN = 1,
  parameter int N_RD   = 6,
  parameter int N_WR   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_RD-1:0]          rd_req,
  input  logic [N_RD*ADDR_W-1:0]   rd_addr,
  output logic [N_RD-1:0]          rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic [N_RD-1:0]          rd_perr,
  input  logic [N_WR-1:0]          wr_req,
  input  logic [N_WR*ADDR_W-1:0]   wr_addr,
  input  logic [N_WR*DATA_W-1:0]   wr_data,
  output logic [N_WR-1:0]          wr_done,
  output logic [ADDR_W-1:0]        sram_addr,
  output logic                     sram_adsc_n,
  output logic                     sram_oe_n,
  output logic                     sram_cs_n,
  output logic                     sram_we_n,
  output logic                     sram_dq_oe,
  output logic [DATA_W+PAR_EN-1:0] sram_dq_out,
  input  logic [DATA_W+PAR_EN-1:0] sram_dq_in
);

  localparam int WPW = ADDR_W + DATA_W;

  logic                 rst_n_s;
  slot_kind_e           kind;
  logic [N_RD-1:0]      rd_sel, rd_pend, rd_take;
  logic [N_WR-1:0]      wr_sel, wr_pend;
  logic                 oe_win;
  logic [N_RD*ADDR_W-1:0] rd_pay;
  logic [N_WR*WPW-1:0]  wr_pay_in, wr_pay;
  logic [ADDR_W-1:0]    addr_mux;
  logic [DATA_W-1:0]    wdata_mux;

  tslot_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_s)
  );

  tslot_seq #(.N_RD(N_RD), .N_WR(N_WR)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .kind_o   (kind),
    .rd_sel_o (rd_sel),
    .wr_sel_o (wr_sel),
    .oe_win_o (oe_win)
  );

  tslot_req_bank #(.N(N_RD), .PW(ADDR_W)) u_rbank (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .req_i   (rd_req),
    .pay_i   (rd_addr),
    .serve_i (rd_sel),
    .pend_o  (rd_pend),
    .pay_o   (rd_pay),
    .done_o  (rd_take)
  );

  for (genvar j = 0; j < N_WR; j++) begin : g_wpack
    assign wr_pay_in[j*WPW +: WPW] = {wr_data[j*DATA_W +: DATA_W],
                                      wr_addr[j*ADDR_W +: ADDR_W]};
  end

  tslot_req_bank #(.N(N_WR), .PW(WPW)) u_wbank (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .req_i   (wr_req),
    .pay_i   (wr_pay_in),
    .serve_i (wr_sel),
    .pend_o  (wr_pend),
    .pay_o   (wr_pay),
    .done_o  (wr_done)
  );

  tslot_rd_return #(.N(N_RD), .DW(DATA_W), .PAR(PAR_EN)) u_ret (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .take_i  (rd_take),
    .dq_i    (sram_dq_in),
    .valid_o (rd_valid),
    .data_o  (rd_data),
    .perr_o  (rd_perr)
  );

  always_comb begin
    addr_mux  = '0;
    wdata_mux = '0;
    for (int i = 0; i < N_RD; i++) begin
      if (rd_sel[i]) addr_mux = rd_pay[i*ADDR_W +: ADDR_W];
    end
    for (int j = 0; j < N_WR; j++) begin
      if (wr_sel[j]) begin
        addr_mux  = wr_pay[j*WPW +: ADDR_W];
        wdata_mux = wr_pay[j*WPW + ADDR_W +: DATA_W];
      end
    end
  end

  assign sram_addr   = addr_mux;
  assign sram_adsc_n = ~rst_n_s;
  assign sram_oe_n   = ~oe_win;
  assign sram_cs_n   = ~(|(rd_sel & rd_pend) | |(wr_sel & wr_pend));
  assign sram_we_n   = ~(|(wr_sel & wr_pend));
  assign sram_dq_oe  = (kind == SLOT_WR);

  if (PAR_EN != 0) begin : g_wpar
    assign sram_dq_out = {^wdata_mux, wdata_mux};
  end else begin : g_wnopar
    assign sram_dq_out = wdata_mux;
  end

  // R4: a write strobe always comes with chip select and a driven bus
  p_we_with_cs_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !sram_we_n |-> (!sram_cs_n && sram_dq_oe));

  // R5: controller and SRAM never drive the bus together
  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    sram_dq_oe |-> sram_oe_n);

  // R6: at most one reader is strobed per cycle
  p_valid_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(rd_valid));

  // R9: a write completion follows a write strobe
  p_done_after_we_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|wr_done) |-> $past(!sram_we_n));

  // R3: the dummy slot never selects memory
  p_gap_idle_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (kind == SLOT_GAP) |-> sram_cs_n);

endmodule

// File: tb/tslot_sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module tslot_sram_ctrl_tb_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NR = 6;
  localparam int NW = 5;
  localparam int NV = 7;

  // rd_mask[19:14] wr_mask[13:9] seed[8:1] flip[0]
  localparam logic [19:0] VEC [NV] = '{
    {6'h3F, 5'h1F, 8'h11, 1'b0},
    {6'h05, 5'h05, 8'h22, 1'b0},
    {6'h00, 5'h00, 8'h33, 1'b0},
    {6'h2A, 5'h0A, 8'h44, 1'b0},
    {6'h04, 5'h00, 8'h55, 1'b1},
    {6'h3F, 5'h00, 8'h11, 1'b0},
    {6'h21, 5'h10, 8'h66, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [NR-1:0]    rd_req;
  logic [NR*AW-1:0] rd_addr;
  logic [NR-1:0]    rd_valid, rd_perr;
  logic [DW-1:0]    rd_data;
  logic [NW-1:0]    wr_req, wr_done;
  logic [NW*AW-1:0] wr_addr;
  logic [NW*DW-1:0] wr_data;
  logic [AW-1:0]    sram_addr;
  logic sram_adsc_n, sram_oe_n, sram_cs_n, sram_we_n, sram_dq_oe;
  logic [DW:0] sram_dq_out, sram_dq_in;

  int checks = 0;
  int errors = 0;
  int bslot  = 0;
  bit finished = 0;
  logic flip = 1'b0;

  logic [32:0] mem [256];
  logic [32:0] exp_mem [256];
  logic [7:0]  ma_q;
  logic        mrd_q;
  logic [7:0]  last_ra [NR];
  logic [7:0]  last_wa [NW];
  logic [31:0] last_wd [NW];

  always #2.5 clk = ~clk;

  tslot_sram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_perr(rd_perr),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done),
    .sram_addr(sram_addr), .sram_adsc_n(sram_adsc_n), .sram_oe_n(sram_oe_n),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_dq_oe(sram_dq_oe),
    .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in)
  );

  function automatic logic [32:0] init_word(input int i);
    logic [31:0] d;
    d = {8'(i), 8'h3C, ~8'(i), 8'(i * 7)};
    return {^d, d};
  endfunction

  function automatic logic [31:0] mk_data(input logic [7:0] sd, input int j);
    return {sd, 8'(j * 17), ~sd, 8'h5A};
  endfunction

  // flow-through SRAM model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
      mrd_q <= 1'b0;
      ma_q  <= '0;
    end else begin
      mrd_q <= !sram_cs_n && sram_we_n;
      ma_q  <= sram_addr[7:0];
      if (!sram_cs_n && !sram_we_n) mem[sram_addr[7:0]] <= sram_dq_out;
    end
  end

  assign sram_dq_in = (mrd_q && !sram_oe_n) ? (mem[ma_q] ^ {32'b0, flip}) : '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    bslot = (bslot + 1) % 12;
  endtask

  task automatic run_frame(input logic [5:0] rm, input logic [4:0] wm,
                           input logic [7:0] sd, input logic fl);
    logic [32:0] er [NR];
    logic [31:0] wd;
    while (bslot != 11) step();
    for (int i = 0; i < NR; i++) begin
      if (rm[i]) begin
        rd_req[i] = 1'b1;
        last_ra[i] = sd + 8'(i * 3);
        rd_addr[i*AW +: AW] = {8'h00, last_ra[i]};
      end
    end
    for (int j = 0; j < NW; j++) begin
      if (wm[j]) begin
        wr_req[j] = 1'b1;
        last_wa[j] = sd + 8'(j * 3);
        last_wd[j] = mk_data(sd, j);
        wr_addr[j*AW +: AW] = {8'h00, last_wa[j]};
        wr_data[j*DW +: DW] = last_wd[j];
      end
    end
    for (int i = 0; i < NR; i++) er[i] = exp_mem[last_ra[i]];
    flip = fl;
    step();
    rd_req = '0;
    wr_req = '0;
    for (int s = 0; s < 13; s++) begin
      if (s > 0) step();
      if (s < 12) begin
        chk("R1 adsc_n", 64'(sram_adsc_n), 64'(0));
        chk("R1 oe_n", 64'(sram_oe_n), 64'((s >= 1 && s <= 6) ? 0 : 1));
        chk("R5 dq_oe", 64'(sram_dq_oe), 64'((s >= 7) ? 1 : 0));
        if (s < 6) begin
          chk("R3 cs_n rd", 64'(sram_cs_n), 64'(!rm[s]));
          chk("R4 we_n rd", 64'(sram_we_n), 64'(1));
          chk("R2 addr rd", 64'(sram_addr), 64'(last_ra[s]));
        end else if (s == 6) begin
          chk("R3 cs_n gap", 64'(sram_cs_n), 64'(1));
          chk("R2 addr gap", 64'(sram_addr), 64'(0));
        end else begin
          chk("R3 cs_n wr", 64'(sram_cs_n), 64'(!wm[s-7]));
          chk("R4 we_n wr", 64'(sram_we_n), 64'(!wm[s-7]));
          chk("R2 addr wr", 64'(sram_addr), 64'(last_wa[s-7]));
          if (wm[s-7]) begin
            wd = last_wd[s-7];
            chk("R4 wdata", 64'(sram_dq_out), 64'({^wd, wd}));
          end
        end
        if (s >= 2 && s <= 7 && rm[s-2]) begin
          chk("R6 valid", 64'(rd_valid), 64'(6'b1 << (s - 2)));
          chk("R6 data", 64'(rd_data), 64'(er[s-2][31:0] ^ {31'b0, fl}));
          chk("R7 perr", 64'(rd_perr), fl ? 64'(6'b1 << (s - 2)) : 64'(0));
        end else begin
          chk("R6 no valid", 64'(rd_valid), 64'(0));
          chk("R7 no perr", 64'(rd_perr), 64'(0));
        end
      end
      if (s >= 1) begin
        chk("R9 wr_done", 64'(wr_done),
            (s >= 8 && wm[s-8]) ? 64'(5'b1 << (s - 8)) : 64'(0));
      end
    end
    flip = 1'b0;
    for (int j = 0; j < NW; j++) begin
      if (wm[j]) exp_mem[last_wa[j]] = {^last_wd[j], last_wd[j]};
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    rd_req  = '0;
    wr_req  = '0;
    rd_addr = '0;
    wr_addr = '0;
    wr_data = '0;
    for (int i = 0; i < 256; i++) exp_mem[i] = init_word(i);
    for (int i = 0; i < NR; i++) last_ra[i] = '0;
    for (int j = 0; j < NW; j++) begin
      last_wa[j] = '0;
      last_wd[j] = '0;
    end
    repeat (4) @(negedge clk);
    // R10: quiet pins under reset
    chk("R10 cs_n", 64'(sram_cs_n), 64'(1));
    chk("R10 we_n", 64'(sram_we_n), 64'(1));
    chk("R10 oe_n", 64'(sram_oe_n), 64'(1));
    chk("R10 dq_oe", 64'(sram_dq_oe), 64'(0));
    chk("R10 strobes", 64'({rd_valid, rd_perr, wr_done}), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 still slot0", 64'(sram_oe_n), 64'(1));
    @(negedge clk);
    chk("R10 slot1 start", 64'(sram_oe_n), 64'(0));
    bslot = 1;

    for (int e = 0; e < NV; e++) begin
      run_frame(VEC[e][19:14], VEC[e][13:9], VEC[e][8:1], VEC[e][0]);
    end

    // R8: request raised in its own slot waits a full frame
    while (bslot != 2) step();
    rd_req[2] = 1'b1;
    last_ra[2] = 8'h90;
    rd_addr[2*AW +: AW] = 16'h0090;
    chk("R8 not now", 64'(sram_cs_n), 64'(1));
    step();
    rd_req = '0;
    while (bslot != 2) step();
    chk("R8 next frame cs_n", 64'(sram_cs_n), 64'(0));
    chk("R8 next frame addr", 64'(sram_addr), 64'h90);
    step();
    step();
    chk("R8 valid", 64'(rd_valid), 64'(6'b000100));
    chk("R8 data", 64'(rd_data), 64'(exp_mem[8'h90][31:0]));

    // R3: a later frame with no requests leaves everything idle
    run_frame(6'h00, 5'h00, 8'h77, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule